// File: doc/BRIEF.md
# System Configuration Registers with Interrupt-Line Routing

This block is a small file of 32-bit configuration registers on a simple read/write bus. Each register follows its own write rule. Some bits are plain masked storage. Some can only be set by software and are cleared only by reset. One bit can only be cleared by software and is set again only by reset. One flag is set by hardware and cleared when software writes a 1 to it. The features these bits would normally control (memory remapping, a firewall, SRAM erase and write protection) are not part of the block. Only the register behaviour is built.

The block also holds four line-select registers. Together they route one of eight GPIO ports onto each of 16 interrupt lines. Every line has a 4-bit port selector, and the line output follows pin n of the selected port, registered once. System software programs the selectors once at start-up. The interrupt controller then sees one level per line, whichever port drives it.

Top module: `sys_cfg_router`

## Requirements
- R1: After reset, the register at 0x04 reads 0x7C000001 and every other mapped register reads 0.
- R2: A write to 0x00 keeps only the bits in mask 0x00000107. A write to 0x24 keeps only the bits in mask 0x000000FF.
- R3: At 0x04, the bits in mask 0xFCFF0100 take the written value. Bit 0 is cleared by writing 0, but writing 1 never sets it again; only reset sets it.
- R4: The line-select registers at 0x08, 0x0C, 0x10 and 0x14 store only their low 16 bits. Register k holds the selector for line 4k+j in bits 4j+3:4j.
- R5: At 0x1C, bits 3:0 are set by writing 1 and stay set until reset. Writing 1 to bit 8 clears it, and writing 0 to bit 8 has no effect. All other bits read 0.
- R6: A pulse on parity_err sets bit 8 of 0x1C. When the pulse and a write-one-to-clear of that bit fall in the same cycle, the bit ends up set.
- R7: The registers at 0x20 and 0x28 OR each written value into their contents. No write clears a bit.
- R8: Writes to 0x18 are ignored, and 0x18 always reads 0.
- R9: An access is ignored when its byte offset is unmapped (0x2C and up within the 0x400-byte window) or when its address bits 1:0 are not zero. A write then changes nothing, and a read returns 0.
- R10: Read data appears on bus_rdata in the cycle after the read request. In the cycle after a cycle with no read, bus_rdata is 0.
- R11: One cycle after a sample, irq_lines[n] equals pin n of port P, where P is line n's selector and P < 8. Pin n is gpio_pins[P*16+n]. Pins of other ports have no effect on the line.
- R12: A line whose selector is 8 or more drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| parity_err | input | 1 | Hardware pulse that sets the parity flag |
| gpio_pins | input | 128 | Pin levels, port P pin n at bit P*16+n |
| irq_lines | output | 16 | Routed interrupt line levels, registered |

## Verification
The assertions check several properties on every cycle. The clear-only firewall bit never rises outside reset. The lock bits and both protect registers never lose a set bit. A parity pulse always leaves the flag set. Status, misaligned and idle reads return zero. A line with a selector of 8 or more stays low.

The per-register masks, the exact reset values and the selector bit positions within each line-select register can only be shown by the bench's write and read-back sequences. The same holds for which port actually reaches each line, which the bench shows by driving each port in turn.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned WIN_ADDR_W    = 10;                 // 0x400-byte window
  localparam int unsigned IDX_W         = WIN_ADDR_W - 2;     // word index width
  localparam int unsigned NUM_LINES     = 16;
  localparam int unsigned LINES_PER_SEL = 4;
  localparam int unsigned NUM_SEL_REGS  = NUM_LINES / LINES_PER_SEL;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_REMAP = 8'd0;
  localparam logic [IDX_W-1:0] IDX_CFG1  = 8'd1;
  localparam logic [IDX_W-1:0] IDX_SEL0  = 8'd2;
  localparam logic [IDX_W-1:0] IDX_STAT  = 8'd6;
  localparam logic [IDX_W-1:0] IDX_CFG2  = 8'd7;
  localparam logic [IDX_W-1:0] IDX_WP1   = 8'd8;
  localparam logic [IDX_W-1:0] IDX_KEY   = 8'd9;
  localparam logic [IDX_W-1:0] IDX_WP2   = 8'd10;

  localparam logic [WORD_W-1:0] MASK_REMAP   = 32'h0000_0107;
  localparam logic [WORD_W-1:0] MASK_KEY     = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] MASK_CFG1_RW = 32'hFCFF_0100;
  localparam logic [WORD_W-1:0] MASK_SEL     = 32'h0000_FFFF;
  localparam logic [WORD_W-1:0] RST_CFG1     = 32'h7C00_0001;
  localparam int unsigned       CFG2_FLAG    = 8;

  typedef struct packed {
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] data;
  } bus_req_t;
endpackage

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
  import sys_cfg_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  bus_req_t                      req,
  input  logic                          parity_err,
  output logic [WORD_W-1:0]             rd_value,
  output logic [WORD_W-1:0]             cfg1_q,
  output logic [WORD_W-1:0]             cfg2_q,
  output logic [WORD_W-1:0]             wp1_q,
  output logic [WORD_W-1:0]             wp2_q,
  output logic [NUM_LINES*SEL_W-1:0]    sel_flat
);
  localparam int unsigned SEL_BITS = LINES_PER_SEL * SEL_W;

  logic [WORD_W-1:0] remap_q, key_q;
  logic [SEL_BITS-1:0] sel_q [NUM_SEL_REGS];

  wire [WORD_W-1:0] wd = req.data;

  // lock bits only accumulate; the flag has a hardware set that beats a W1C
  logic [3:0] lock_next;
  logic       flag_next;
  always_comb begin
    lock_next = cfg2_q[3:0];
    flag_next = cfg2_q[CFG2_FLAG];
    if (req.wr && req.idx == IDX_CFG2) begin
      lock_next = lock_next | wd[3:0];
      if (wd[CFG2_FLAG]) flag_next = 1'b0;
    end
    if (parity_err) flag_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remap_q <= '0;
      key_q   <= '0;
      cfg1_q  <= RST_CFG1;
      cfg2_q  <= '0;
      wp1_q   <= '0;
      wp2_q   <= '0;
    end else begin
      cfg2_q <= {{(WORD_W-CFG2_FLAG-1){1'b0}}, flag_next, 4'b0000, lock_next};
      if (req.wr) begin
        unique case (req.idx)
          IDX_REMAP: remap_q <= wd & MASK_REMAP;
          IDX_KEY:   key_q   <= wd & MASK_KEY;
          IDX_CFG1:  cfg1_q  <= (wd & MASK_CFG1_RW) |
                                {{(WORD_W-1){1'b0}}, cfg1_q[0] & wd[0]};
          IDX_WP1:   wp1_q   <= wp1_q | wd;
          IDX_WP2:   wp2_q   <= wp2_q | wd;
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NUM_SEL_REGS; k++) begin : g_sel
    wire hit = req.wr && (req.idx == IDX_SEL0 + IDX_W'(k));
    always_ff @(posedge clk) begin
      if (rst)      sel_q[k] <= '0;
      else if (hit) sel_q[k] <= wd[SEL_BITS-1:0];
    end
    assign sel_flat[k*SEL_BITS +: SEL_BITS] = sel_q[k];
  end

  always_comb begin
    rd_value = '0;
    unique case (req.idx)
      IDX_REMAP: rd_value = remap_q;
      IDX_CFG1:  rd_value = cfg1_q;
      IDX_STAT:  rd_value = '0;
      IDX_CFG2:  rd_value = cfg2_q;
      IDX_WP1:   rd_value = wp1_q;
      IDX_KEY:   rd_value = key_q;
      IDX_WP2:   rd_value = wp2_q;
      default:   rd_value = '0;
    endcase
    for (int k = 0; k < NUM_SEL_REGS; k++)
      if (req.idx == IDX_SEL0 + IDX_W'(k))
        rd_value = WORD_W'(sel_q[k]) & MASK_SEL;
  end
endmodule

// File: rtl/sys_cfg_route.sv
module sys_cfg_route
  import sys_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_flat,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins,
  output logic [NUM_LINES-1:0]           irq_q
);
  localparam int unsigned PIDX_W = $clog2(NUM_PORTS);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] column;
    logic [SEL_W-1:0]     sel;
    logic                 pick;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign column[p] = pins[p*NUM_LINES + n];
    end

    assign sel  = sel_flat[n*SEL_W +: SEL_W];
    assign pick = (int'(sel) < NUM_PORTS) ? column[sel[PIDX_W-1:0]] : 1'b0;

    always_ff @(posedge clk) begin
      if (rst) irq_q[n] <= 1'b0;
      else     irq_q[n] <= pick;
    end
  end
endmodule

// File: rtl/sys_cfg_router.sv
module sys_cfg_router
  import sys_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_we,
  input  logic [WIN_ADDR_W-1:0]          bus_addr,
  input  logic [WORD_W-1:0]              bus_wdata,
  output logic [WORD_W-1:0]              bus_rdata,
  input  logic                           parity_err,
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_pins,
  output logic [NUM_LINES-1:0]           irq_lines
);
  wire aligned = (bus_addr[1:0] == 2'b00);
  wire rd_go   = bus_sel && !bus_we && aligned;

  bus_req_t          req;
  logic [WORD_W-1:0] rd_value;
  logic [WORD_W-1:0] cfg1_q, cfg2_q, wp1_q, wp2_q;
  logic [NUM_LINES*SEL_W-1:0] sel_flat;

  assign req.wr   = bus_sel && bus_we && aligned;
  assign req.idx  = bus_addr[WIN_ADDR_W-1:2];
  assign req.data = bus_wdata;

  sys_cfg_regs #(.SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .parity_err (parity_err),
    .rd_value   (rd_value),
    .cfg1_q     (cfg1_q),
    .cfg2_q     (cfg2_q),
    .wp1_q      (wp1_q),
    .wp2_q      (wp2_q),
    .sel_flat   (sel_flat)
  );

  sys_cfg_route #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_route (
    .clk      (clk),
    .rst      (rst),
    .sel_flat (sel_flat),
    .pins     (gpio_pins),
    .irq_q    (irq_lines)
  );

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_value;
    else            bus_rdata <= '0;
  end
endmodule

// File: rtl/sys_cfg_checker.sv
module sys_cfg_checker
  import sys_cfg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned SEL_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_sel,
  input logic                       bus_we,
  input logic [WIN_ADDR_W-1:0]      bus_addr,
  input logic [WORD_W-1:0]          bus_rdata,
  input logic                       parity_err,
  input logic [NUM_LINES-1:0]       irq_lines,
  input logic [WORD_W-1:0]          cfg1_q,
  input logic [WORD_W-1:0]          cfg2_q,
  input logic [WORD_W-1:0]          wp1_q,
  input logic [WORD_W-1:0]          wp2_q,
  input logic [NUM_LINES*SEL_W-1:0] sel_flat
);
  wire rd_req = bus_sel && !bus_we;

  assert_fw_no_set_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$rose(cfg1_q[0]));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(cfg2_q[3:0]) & ~cfg2_q[3:0]) == 4'b0000));

  assert_perr_sets_R6: assert property (@(posedge clk) disable iff (rst)
    parity_err |=> cfg2_q[CFG2_FLAG]);

  assert_wp1_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(wp1_q) & ~wp1_q) == '0));

  assert_wp2_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(wp2_q) & ~wp2_q) == '0));

  assert_stat_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_addr == 10'h018) |=> (bus_rdata == '0));

  assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata == '0));

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
    assert_dead_sel_R12: assert property (@(posedge clk) disable iff (rst)
      (int'(sel_flat[n*SEL_W +: SEL_W]) >= NUM_PORTS) |=> !irq_lines[n]);
  end
endmodule

bind sys_cfg_router sys_cfg_checker #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .parity_err (parity_err),
  .irq_lines  (irq_lines),
  .cfg1_q     (cfg1_q),
  .cfg2_q     (cfg2_q),
  .wp1_q      (wp1_q),
  .wp2_q      (wp2_q),
  .sel_flat   (sel_flat)
);

// File: tb/sys_cfg_router_bench.sv
module sys_cfg_router_bench;
  localparam int NPORT = 8;
  localparam int NLINE = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_sel = 1'b0, bus_we = 1'b0, parity_err = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [NPORT*NLINE-1:0] gpio_pins = '0;
  logic [NLINE-1:0] irq_lines;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sys_cfg_router u_sys_cfg_router (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .parity_err(parity_err), .gpio_pins(gpio_pins), .irq_lines(irq_lines)
  );

  // vector: {we, addr[9:0], data_or_expected[31:0], req[3:0]}
  localparam int NVEC = 41;
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b0, 10'h000, 32'h0000_0000, 4'd1},   // R1 reset values
    {1'b0, 10'h004, 32'h7C00_0001, 4'd1},
    {1'b0, 10'h01C, 32'h0000_0000, 4'd1},
    {1'b0, 10'h020, 32'h0000_0000, 4'd1},
    {1'b0, 10'h028, 32'h0000_0000, 4'd1},
    {1'b1, 10'h000, 32'hFFFF_FFFF, 4'd2},   // R2 remap mask
    {1'b0, 10'h000, 32'h0000_0107, 4'd2},
    {1'b1, 10'h024, 32'h1234_5678, 4'd2},   // R2 key mask
    {1'b0, 10'h024, 32'h0000_0078, 4'd2},
    {1'b1, 10'h004, 32'hFFFF_FFFE, 4'd3},   // R3 clear bit 0
    {1'b0, 10'h004, 32'hFCFF_0100, 4'd3},
    {1'b1, 10'h004, 32'hFFFF_FFFF, 4'd3},   // R3 bit 0 cannot be set
    {1'b0, 10'h004, 32'hFCFF_0100, 4'd3},
    {1'b1, 10'h004, 32'h0000_0000, 4'd3},
    {1'b0, 10'h004, 32'h0000_0000, 4'd3},
    {1'b1, 10'h008, 32'hABCD_1234, 4'd4},   // R4 low 16 bits only
    {1'b0, 10'h008, 32'h0000_1234, 4'd4},
    {1'b1, 10'h014, 32'hFFFF_0000, 4'd4},
    {1'b0, 10'h014, 32'h0000_0000, 4'd4},
    {1'b1, 10'h01C, 32'h0000_0005, 4'd5},   // R5 lock set
    {1'b0, 10'h01C, 32'h0000_0005, 4'd5},
    {1'b1, 10'h01C, 32'h0000_000A, 4'd5},
    {1'b0, 10'h01C, 32'h0000_000F, 4'd5},
    {1'b1, 10'h01C, 32'h0000_0000, 4'd5},   // R5 no clear
    {1'b0, 10'h01C, 32'h0000_000F, 4'd5},
    {1'b1, 10'h020, 32'h0000_0011, 4'd7},   // R7 accumulate
    {1'b1, 10'h020, 32'h0000_0100, 4'd7},
    {1'b0, 10'h020, 32'h0000_0111, 4'd7},
    {1'b1, 10'h020, 32'h0000_0000, 4'd7},
    {1'b0, 10'h020, 32'h0000_0111, 4'd7},
    {1'b1, 10'h028, 32'h8000_0000, 4'd7},
    {1'b0, 10'h028, 32'h8000_0000, 4'd7},
    {1'b1, 10'h018, 32'hFFFF_FFFF, 4'd8},   // R8 status ignored
    {1'b0, 10'h018, 32'h0000_0000, 4'd8},
    {1'b1, 10'h3FC, 32'hFFFF_FFFF, 4'd9},   // R9 unmapped
    {1'b0, 10'h3FC, 32'h0000_0000, 4'd9},
    {1'b1, 10'h02C, 32'hFFFF_FFFF, 4'd9},
    {1'b0, 10'h02C, 32'h0000_0000, 4'd9},
    {1'b1, 10'h025, 32'hFFFF_FFFF, 4'd9},   // R9 misaligned write ignored
    {1'b0, 10'h024, 32'h0000_0078, 4'd9},
    {1'b0, 10'h025, 32'h0000_0000, 4'd9}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d, input logic perr);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; parity_err = perr;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; parity_err = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  logic [3:0] sel_model [NLINE];

  function automatic logic [NLINE-1:0] route_exp(input logic [NPORT*NLINE-1:0] pins);
    logic [NLINE-1:0] r;
    for (int n = 0; n < NLINE; n++)
      r[n] = (int'(sel_model[n]) < NPORT) ? pins[int'(sel_model[n])*NLINE + n] : 1'b0;
    return r;
  endfunction

  task automatic route_check(input int req, input logic [NPORT*NLINE-1:0] pins);
    gpio_pins = pins;
    @(negedge clk);
    check(req, {16'h0, irq_lines}, {16'h0, route_exp(pins)});
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, {16'h0, irq_lines}, 32'h0);    // R1 lines low after reset
    check(10, bus_rdata, 32'h0);            // R10 idle read data

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][46]) bus_write(VEC[i][45:36], VEC[i][35:4], 1'b0);
      else begin
        bus_read(VEC[i][45:36], rd);
        check(int'(VEC[i][3:0]), rd, VEC[i][35:4]);
      end
    end

    // R10: one cycle after the read is dropped, data returns to 0
    @(negedge clk);
    check(10, bus_rdata, 32'h0);

    // R6: hardware pulse sets the flag
    parity_err = 1'b1; @(negedge clk); parity_err = 1'b0;
    bus_read(10'h01C, rd); check(6, rd, 32'h0000_010F);
    bus_write(10'h01C, 32'h0, 1'b0);          // R5 writing 0 keeps flag
    bus_read(10'h01C, rd); check(5, rd, 32'h0000_010F);
    bus_write(10'h01C, 32'h100, 1'b0);        // R5 write-one-to-clear
    bus_read(10'h01C, rd); check(5, rd, 32'h0000_000F);
    bus_write(10'h01C, 32'h100, 1'b1);        // R6 set wins over clear
    bus_read(10'h01C, rd); check(6, rd, 32'h0000_010F);

    // R11 / R12 routing: line0->3, line1->8 (dead), line2->0, line3->7, line15->2
    bus_write(10'h008, 32'h0000_7083, 1'b0);
    bus_write(10'h00C, 32'h0, 1'b0);
    bus_write(10'h010, 32'h0, 1'b0);
    bus_write(10'h014, 32'h0000_2000, 1'b0);
    for (int n = 0; n < NLINE; n++) sel_model[n] = 4'd0;
    sel_model[0] = 4'd3; sel_model[1] = 4'd8; sel_model[3] = 4'd7; sel_model[15] = 4'd2;
    bus_read(10'h008, rd); check(4, rd, 32'h0000_7083);   // R4 read-back

    route_check(12, '1);                      // R12 line 1 stays low
    for (int p = 0; p < NPORT; p++) begin
      logic [NPORT*NLINE-1:0] pat = '0;
      pat[p*NLINE +: NLINE] = 16'hFFFF;
      route_check(11, pat);                   // R11 only the selected port matters
    end
    route_check(11, {NPORT{16'hA5A5}});
    route_check(11, '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule